// File: doc/BRIEF.md
# I2C Clock Low/High Period Generator

This block produces the clock line for an I2C bus master. It holds the line low for a programmed number of counts. It then releases the line and waits until the sampled line level reads high. Only then does it count a programmed number of high counts before it pulls the line low again. The low count starts on the cycle the block begins driving low. The high count starts only after the line is sensed high. Rise time and any slave that stretches the clock therefore lengthen the high part of the period, and the low part is never shortened.

Each count is nine bits wide. The lower eight bits come from two dedicated byte inputs. The ninth bit of each count comes from a separate control byte: bit 7 extends the low count and bit 6 extends the high count. A build parameter removes the extension, and then the counts are limited to 255. A prescale select makes each count last one or two system clocks. A neighbouring byte engine receives one-cycle strobes on the cycle the block starts driving low and on the first cycle of the sensed high period. It uses them to time its data shifting.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, `sclDriveLow` is 0 and neither strobe fires from the cycle after `enable` is sampled low. A new enable always starts a complete low period, because disabling clears the period counter.
- R2: The low period starts in the cycle after `enable` (or the end of a high period) is sampled. `sclDriveLow` stays 1 for exactly effLow × div cycles, where div is 1 or 2 as set by R6.
- R3: After release, the block samples `sclIn` once per cycle. On the first edge where it reads 1, the high count starts. `riseStrobe` is 1 in the first high-count cycle, and the high count lasts exactly effHigh × div cycles before `sclDriveLow` returns to 1.
- R4: With the extension present, effLow is taken from {`extReg[7]`, `lowCount`} and effHigh from {`extReg[6]`, `highCount`}, each a 9-bit value. Other bits of `extReg` have no effect.
- R5: With `EXT_PRESENT`=0, `extReg` has no effect, the counts are the 8-bit byte values, and the largest count is 255.
- R6: `prescaleSel`=0 makes one count last one clock. `prescaleSel`=1 makes it last two clocks.
- R7: A count value of 0 behaves exactly like a count of 1.
- R8: `fallStrobe` is 1 for exactly one cycle, namely the first cycle of every low period. It never coincides with `riseStrobe`.
- R9: While the line is released and `sclIn` reads 0 (stretching), the block does not drive low, does not count, and does not raise `riseStrobe`. `riseStrobe` follows one cycle after `sclIn` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Bus clock generation enable |
| prescaleSel | input | 1 | 0: one clock per count, 1: two clocks per count |
| lowCount | input | 8 | Low period count, bits 7:0 |
| highCount | input | 8 | High period count, bits 7:0 |
| extReg | input | 8 | Control byte; bit 7 is low-count bit 8, bit 6 is high-count bit 8 |
| sclIn | input | 1 | Sampled clock line level |
| sclDriveLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| fallStrobe | output | 1 | One-cycle pulse at the start of each low period |
| riseStrobe | output | 1 | One-cycle pulse at the start of each counted high period |

## Verification
The bench sweeps small low and high counts under both prescale settings and includes the zero counts. A design that did not map zero to one would stall or wrap through the full range, and a prescaler not reset at each phase start would be off by one clock. Ninth-bit cases are run on a full build and on a build without the extension. Swapped or ignored extension bits show up as periods off by 256 counts. A stretch test holds the line low after release, and a design that counted the high period during the stretch would end the period early. Disabling mid-period and re-enabling shows whether the counter was left holding a stale partial count.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // strobes from the phase control to the period counter
  typedef struct packed {
    logic clear;    // restart the count at zero
    logic tick;     // one count has elapsed this cycle
    logic selHigh;  // compare against the high period limit
  } cnt_ctrl_t;

endpackage

// File: rtl/scl_count_dp.sv
module scl_count_dp
  import scl_timing_pkg::*;
#(
  parameter int BASE_W       = 8,
  parameter int REG_W        = 8,
  parameter bit EXT_PRESENT  = 1'b1,
  parameter int LOW_EXT_BIT  = 7,
  parameter int HIGH_EXT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] lowCount,
  input  logic [BASE_W-1:0] highCount,
  input  logic [REG_W-1:0]  extReg,
  input  cnt_ctrl_t         ctl,
  output logic              phaseDone
);

  localparam int CNT_W = BASE_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_COUNT =
    EXT_PRESENT ? {CNT_W{1'b1}} : {1'b0, {BASE_W{1'b1}}};

  logic             lowTop;
  logic             highTop;
  logic [CNT_W-1:0] lowRaw;
  logic [CNT_W-1:0] highRaw;
  logic [CNT_W-1:0] effLow;
  logic [CNT_W-1:0] effHigh;
  logic [CNT_W-1:0] effSel;
  logic [CNT_W-1:0] rawSel;
  logic [CNT_W-1:0] cnt;

  generate
    if (EXT_PRESENT) begin : g_ext
      assign lowTop  = extReg[LOW_EXT_BIT];
      assign highTop = extReg[HIGH_EXT_BIT];
    end else begin : g_noext
      logic unusedExt;
      assign unusedExt = ^extReg;
      assign lowTop    = 1'b0;
      assign highTop   = 1'b0;
    end
  endgenerate

  assign lowRaw  = {lowTop, lowCount};
  assign highRaw = {highTop, highCount};

  // a zero count would never terminate; run it as a single count
  assign effLow  = (lowRaw  == '0) ? ONE : lowRaw;
  assign effHigh = (highRaw == '0) ? ONE : highRaw;

  assign effSel = ctl.selHigh ? effHigh : effLow;
  assign rawSel = ctl.selHigh ? highRaw : lowRaw;

  // >= guards against a limit lowered in the middle of a phase
  assign phaseDone = ctl.tick && (cnt >= (effSel - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl.clear) begin
      cnt <= '0;
    end else if (ctl.tick) begin
      cnt <= cnt + ONE;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (cnt == '0));

  p_cnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_COUNT);

  p_zero_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.tick && (rawSel == '0)) |-> phaseDone);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timing_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      prescaleSel,
  input  logic      sclIn,
  input  logic      phaseDone,
  output cnt_ctrl_t ctl,
  output logic      sclDriveLow,
  output logic      fallStrobe,
  output logic      riseStrobe
);

  phase_e state;
  phase_e nextState;
  logic   preQ;
  logic   fallQ;
  logic   riseQ;
  logic   counting;
  logic   tick;

  assign counting = (state == PH_LOW) || (state == PH_HIGH);
  assign tick     = counting && (!prescaleSel || preQ);

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE: if (enable)    nextState = PH_LOW;
      PH_LOW:  if (phaseDone) nextState = PH_WAIT;
      PH_WAIT: if (sclIn)     nextState = PH_HIGH;
      PH_HIGH: if (phaseDone) nextState = PH_LOW;
      default:                nextState = PH_IDLE;
    endcase
    if (!enable) nextState = PH_IDLE;
  end

  always_comb begin
    ctl = '{clear:   (!counting) || (nextState != state),
            tick:    tick,
            selHigh: (state == PH_HIGH)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      preQ  <= 1'b0;
      fallQ <= 1'b0;
      riseQ <= 1'b0;
    end else begin
      state <= nextState;
      preQ  <= ctl.clear ? 1'b0 : (prescaleSel ? ~preQ : 1'b0);
      fallQ <= (nextState == PH_LOW)  && (state != PH_LOW);
      riseQ <= (nextState == PH_HIGH) && (state != PH_HIGH);
    end
  end

  assign sclDriveLow = (state == PH_LOW);
  assign fallStrobe  = fallQ;
  assign riseStrobe  = riseQ;

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAIT && !sclIn && enable) |=> (state == PH_WAIT && !riseStrobe));

  p_rise_sensed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    riseStrobe |-> ($past(sclIn) && $past(state == PH_WAIT)));

  p_prescale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescaleSel) |=> (!tick || !prescaleSel));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int BASE_W       = 8,
  parameter int REG_W        = 8,
  parameter bit EXT_PRESENT  = 1'b1,
  parameter int LOW_EXT_BIT  = 7,
  parameter int HIGH_EXT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              prescaleSel,
  input  logic [BASE_W-1:0] lowCount,
  input  logic [BASE_W-1:0] highCount,
  input  logic [REG_W-1:0]  extReg,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              fallStrobe,
  output logic              riseStrobe
);

  cnt_ctrl_t ctl;
  logic      phaseDone;

  scl_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .prescaleSel (prescaleSel),
    .sclIn       (sclIn),
    .phaseDone   (phaseDone),
    .ctl         (ctl),
    .sclDriveLow (sclDriveLow),
    .fallStrobe  (fallStrobe),
    .riseStrobe  (riseStrobe)
  );

  scl_count_dp #(
    .BASE_W       (BASE_W),
    .REG_W        (REG_W),
    .EXT_PRESENT  (EXT_PRESENT),
    .LOW_EXT_BIT  (LOW_EXT_BIT),
    .HIGH_EXT_BIT (HIGH_EXT_BIT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lowCount  (lowCount),
    .highCount (highCount),
    .extReg    (extReg),
    .ctl       (ctl),
    .phaseDone (phaseDone)
  );

  p_off_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sclDriveLow && !fallStrobe && !riseStrobe));

  p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclDriveLow) |-> fallStrobe);

  p_fall_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fallStrobe |=> !fallStrobe);

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fallStrobe && riseStrobe));

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       prescaleSel = 1'b0;
  logic [7:0] lowCount = 8'd0;
  logic [7:0] highCount = 8'd0;
  logic [7:0] extReg = 8'd0;
  logic       hold = 1'b0;
  logic       watchNarrow = 1'b0;

  logic drvW, fallW, riseW, sclInW;
  logic drvN, fallN, riseN, sclInN;
  logic mDrive, mFall, mRise;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclInW = !(drvW || hold);
  assign sclInN = !(drvN || hold);
  assign mDrive = watchNarrow ? drvN  : drvW;
  assign mFall  = watchNarrow ? fallN : fallW;
  assign mRise  = watchNarrow ? riseN : riseW;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescaleSel(prescaleSel),
    .lowCount(lowCount), .highCount(highCount), .extReg(extReg),
    .sclIn(sclInW), .sclDriveLow(drvW), .fallStrobe(fallW), .riseStrobe(riseW)
  );

  scl_timing_gen #(.EXT_PRESENT(1'b0)) u_scl_timing_gen_narrow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescaleSel(prescaleSel),
    .lowCount(lowCount), .highCount(highCount), .extReg(extReg),
    .sclIn(sclInN), .sclDriveLow(drvN), .fallStrobe(fallN), .riseStrobe(riseN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effCount(input int byteVal, input bit topBit, input bit narrow);
    int raw;
    raw = ((narrow ? 0 : int'(topBit)) * 256) + byteVal;
    return (raw == 0) ? 1 : raw;
  endfunction

  // one full period: low length, rise latency, high length
  task automatic runCfg(input int l8, input int h8, input bit lTop, input bit hTop,
                        input bit div2, input bit narrow, input string tag);
    int expL, expH, mul, n;
    mul = div2 ? 2 : 1;
    expL = effCount(l8, lTop, narrow) * mul;
    expH = effCount(h8, hTop, narrow) * mul;
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    watchNarrow = narrow;
    lowCount = 8'(l8);
    highCount = 8'(h8);
    extReg = {lTop, hTop, 6'b10_1101};  // R4: only bits 7 and 6 matter
    prescaleSel = div2;
    enable = 1'b1;
    @(negedge clk);
    check(mFall === 1'b1 && mDrive === 1'b1, {tag, " R8 fall strobe at low start"},
          int'(mFall), 1);
    n = 0;
    while (mDrive === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == expL, {tag, " R2 low length"}, n, expL);
    @(negedge clk);
    check(mRise === 1'b1, {tag, " R3 rise one cycle after sense"}, int'(mRise), 1);
    n = 0;
    while (mFall !== 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == expH, {tag, " R3 high length"}, n, expH);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(drvW === 1'b0 && fallW === 1'b0 && riseW === 1'b0, "R1 reset state",
          int'(drvW), 0);

    // near-exhaustive sweep of small counts, including zero (R7), both prescales (R6)
    for (int d = 0; d < 2; d++) begin
      for (int l = 0; l <= 12; l++) begin
        for (int h = 0; h <= 12; h++) begin
          runCfg(l, h, 1'b0, 1'b0, d[0], 1'b0, "R6 R7 sweep");
        end
      end
    end

    // ninth-bit cases on both builds (R4, R5)
    for (int k = 0; k < 6; k++) begin
      int lv, hv;
      bit lt, ht, dv;
      lv = (k * 37) % 256;
      hv = (k == 2) ? 255 : (k * 11) % 256;
      lt = (k % 2) == 0;
      ht = (k % 3) != 1;
      dv = (k >= 3);
      runCfg(lv, hv, lt, ht, dv, 1'b0, "R4 ext");
      runCfg(lv, hv, lt, ht, dv, 1'b1, "R5 narrow");
    end
    runCfg(255, 255, 1'b1, 1'b1, 1'b1, 1'b0, "R4 max 511");
    runCfg(255, 255, 1'b1, 1'b1, 1'b0, 1'b1, "R5 max 255");

    // stretch (R9)
    enable = 1'b0;
    @(negedge clk);
    watchNarrow = 1'b0;
    lowCount = 8'd3;
    highCount = 8'd4;
    extReg = 8'd0;
    prescaleSel = 1'b0;
    hold = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    n = 0;
    while (drvW === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 3, "R2 low before stretch", n, 3);
    for (int s = 0; s < 5; s++) begin
      check(drvW === 1'b0 && riseW === 1'b0 && fallW === 1'b0, "R9 stretched no count",
            int'(riseW) + int'(drvW), 0);
      @(negedge clk);
    end
    hold = 1'b0;
    @(negedge clk);
    check(riseW === 1'b1, "R9 rise after stretch release", int'(riseW), 1);
    n = 0;
    while (fallW !== 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 4, "R9 full high after stretch", n, 4);

    // disable mid-low, re-enable (R1)
    enable = 1'b0;
    @(negedge clk);
    lowCount = 8'd10;
    highCount = 8'd3;
    enable = 1'b1;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check(drvW === 1'b0 && fallW === 1'b0 && riseW === 1'b0, "R1 released when off",
            int'(drvW), 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check(fallW === 1'b1, "R1 fresh start strobe", int'(fallW), 1);
    n = 0;
    while (drvW === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 10, "R1 full low after re-enable", n, 10);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule